// File: doc/BRIEF.md
# Dual-Channel Interrupt Priority Vectoring

This block merges the interrupt sources of two serial channels, called A and B, into one request on a daisy-chained CPU interrupt line. Each channel offers four source flags: error, receive, status and transmit. The flags come from logic outside the block. A fixed ranking picks the source that wins. The block then builds an 8-bit vector from a programmed base value and, if enabled, a 3-bit code that names the winning source.

When the CPU acknowledges, the block latches the vector and pulses a one-cycle clear for the winning flag, so the source logic can drop it. It then marks that channel as in service. Until a return-from-interrupt arrives, it presents no new request and holds its chain enable-out low. When the block has nothing to offer, it hands the acknowledge down the chain and returns no vector.

The enable registers are inputs. For each channel, bits 4:3 gate receive, bit 0 gates status and bit 1 gates transmit. Bit 2 of channel B's register switches the source code into the vector. A 3-bit mode field picks where the code sits inside the vector.

Top module: `sio_irq_vectoring`

## Requirements
- R1: Within one channel the winner is error, else receive, else status, else transmit. Flag bit order is [3]=error, [2]=receive, [1]=status, [0]=transmit. An acknowledge that wins pulses exactly one clear bit, the winner's, for one cycle.
- R2: Error is always eligible. Receive is eligible only if enable bits 4:3 are not both zero. Status needs enable bit 0, and transmit needs enable bit 1. A flag that is not eligible raises no request.
- R3: Any eligible source of channel A wins over every source of channel B.
- R4: The source code is {channel-is-A, level}, with level 3=error, 2=receive, 1=status and 0=transmit. The code is 7 when nothing is eligible or a channel is in service.
- R5: When bit 2 of channel B's enable is 0, the vector equals the base.
- R6: When that bit is 1 and the mode is 0, 1, 4, 5 or 7, the vector is (base AND 0xE3) OR (code << 2).
- R7: When that bit is 1 and the mode is 2, 3 or 6, the vector is (base AND 0xF8) OR code.
- R8: The request is high exactly when enable-in is high, some source is eligible and no channel is in service.
- R9: An acknowledge taken while the request is high gives, one clock later, a one-cycle valid pulse. The latched vector is the one in force at the acknowledge, and the winning channel enters service.
- R10: While a channel is in service, a further acknowledge returns no vector, clears no flag and is not passed on.
- R11: A return-from-interrupt pulse ends the in-service state. A still-pending source then raises the request again.
- R12: With enable-in low, the request and enable-out are low, and an acknowledge is neither taken nor passed on.
- R13: Enable-out equals enable-in when nothing is eligible and no channel is in service, and is low otherwise. An acknowledge arriving while enable-out is high is passed down in the same cycle.
- R14: After reset no channel is in service and no valid or clear pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_a | input | 4 | Channel A flags: error, receive, status, transmit (bits 3..0) |
| src_b | input | 4 | Channel B flags, same order |
| en_a | input | 8 | Channel A enable register |
| en_b | input | 8 | Channel B enable register; bit 2 puts the code into the vector |
| base_vec | input | 8 | Programmed base vector |
| vmode | input | 3 | Code placement mode |
| ei | input | 1 | Daisy-chain enable-in |
| ack | input | 1 | Interrupt acknowledge |
| reti | input | 1 | Return-from-interrupt pulse |
| irq | output | 1 | Interrupt request |
| eo | output | 1 | Daisy-chain enable-out |
| vec_now | output | 8 | Vector currently in force |
| ack_vec | output | 8 | Vector latched at the last taken acknowledge |
| ack_vld | output | 1 | One-cycle pulse: ack_vec is new |
| ack_pass | output | 1 | Acknowledge handed to the next device |
| clr_a | output | 4 | One-cycle clear pulses for channel A flags |
| clr_b | output | 4 | One-cycle clear pulses for channel B flags |

## Verification
The bench walks channel A down through all four levels, so a reversed rank would show up as the wrong clear bit or the wrong code. It pits a low channel A source against channel B's error, which catches a design that ranks by level across channels. It raises each gated flag with its enable off, so a missing gate would show up as a stray request. It sweeps all eight modes, so a wrong mode set would shift the code into the other bit field. It acknowledges again while a channel is in service and with enable-in low; a design without the lockout would emit a second vector or pass the acknowledge on. An acknowledge with nothing pending must reach the next device and must not produce a vector of its own.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int NSRC = 4;
  localparam int CODE_W = 3;
  localparam int LVL_W = 2;

  // enable register bit positions (decoded by the channel picker)
  localparam int EN_STAT_BIT = 0;
  localparam int EN_TX_BIT   = 1;
  localparam int EN_VEC_BIT  = 2;
  localparam int EN_RX_LO    = 3;
  localparam int EN_RX_HI    = 4;

  typedef enum logic [LVL_W-1:0] {
    LV_TX   = 2'd0,
    LV_STAT = 2'd1,
    LV_RX   = 2'd2,
    LV_ERR  = 2'd3
  } lvl_e;

  localparam logic [CODE_W-1:0] CODE_IDLE = 3'd7;

  // modes that put the code at bits 4:2
  function automatic logic mode_mid(input logic [2:0] m);
    case (m)
      3'd0, 3'd1, 3'd4, 3'd5, 3'd7: mode_mid = 1'b1;
      default:                      mode_mid = 1'b0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] mk_code(input logic is_a, input logic [LVL_W-1:0] lvl);
    mk_code = {is_a, lvl};
  endfunction

endpackage

// File: rtl/sio_chan_pick.sv
module sio_chan_pick
  import sio_irq_pkg::*;
#(
  parameter int EN_W = 8
) (
  input  logic [NSRC-1:0]  src,
  input  logic [EN_W-1:0]  en,
  output logic             elig,
  output logic [LVL_W-1:0] lvl,
  output logic [NSRC-1:0]  win_oh
);

  logic [NSRC-1:0] qual;

  always_comb begin
    qual[LV_ERR]  = src[LV_ERR];
    qual[LV_RX]   = src[LV_RX] & (|en[EN_RX_HI:EN_RX_LO]);
    qual[LV_STAT] = src[LV_STAT] & en[EN_STAT_BIT];
    qual[LV_TX]   = src[LV_TX] & en[EN_TX_BIT];
  end

  // highest index wins
  always_comb begin
    lvl    = '0;
    win_oh = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i]) begin
        lvl    = LVL_W'(i);
        win_oh = NSRC'(1) << i;
      end
    end
  end

  assign elig = |qual;

endmodule

// File: rtl/sio_vec_fmt.sv
module sio_vec_fmt
  import sio_irq_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int MID_LSB = 2
) (
  input  logic [VEC_W-1:0]  base,
  input  logic [CODE_W-1:0] code,
  input  logic              code_en,
  input  logic [2:0]        mode,
  output logic [VEC_W-1:0]  vec
);

  localparam logic [VEC_W-1:0] FIELD = VEC_W'((1 << CODE_W) - 1);
  localparam logic [VEC_W-1:0] MID_MASK = ~(FIELD << MID_LSB);
  localparam logic [VEC_W-1:0] LOW_MASK = ~FIELD;

  logic [VEC_W-1:0] code_ext;
  logic             at_mid;

  assign code_ext = VEC_W'(code);
  assign at_mid   = mode_mid(mode);

  always_comb begin
    if (!code_en)
      vec = base;
    else if (at_mid)
      vec = (base & MID_MASK) | (code_ext << MID_LSB);
    else
      vec = (base & LOW_MASK) | code_ext;
  end

endmodule

// File: rtl/sio_svc_ctl.sv
module sio_svc_ctl
  import sio_irq_pkg::*;
#(
  parameter int NCH = 2,
  parameter int VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 reti,
  input  logic [NCH-1:0]       win_ch,
  input  logic [NCH*NSRC-1:0]  win_src,
  input  logic [VEC_W-1:0]     vec_in,
  output logic [NCH-1:0]       insvc,
  output logic [VEC_W-1:0]     ack_vec,
  output logic                 ack_vld,
  output logic [NCH*NSRC-1:0]  clr
);

  logic [NCH-1:0] insvc_nx;

  always_comb begin
    insvc_nx = reti ? '0 : insvc;
    if (take) insvc_nx = insvc_nx | win_ch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insvc   <= '0;
      ack_vec <= '0;
      ack_vld <= 1'b0;
      clr     <= '0;
    end else begin
      insvc   <= insvc_nx;
      ack_vld <= take;
      clr     <= take ? win_src : '0;
      if (take) ack_vec <= vec_in;
    end
  end

endmodule

// File: rtl/sio_irq_vectoring.sv
module sio_irq_vectoring
  import sio_irq_pkg::*;
#(
  parameter int EN_W = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       src_a,
  input  logic [3:0]       src_b,
  input  logic [EN_W-1:0]  en_a,
  input  logic [EN_W-1:0]  en_b,
  input  logic [VEC_W-1:0] base_vec,
  input  logic [2:0]       vmode,
  input  logic             ei,
  input  logic             ack,
  input  logic             reti,
  output logic             irq,
  output logic             eo,
  output logic [VEC_W-1:0] vec_now,
  output logic [VEC_W-1:0] ack_vec,
  output logic             ack_vld,
  output logic             ack_pass,
  output logic [3:0]       clr_a,
  output logic [3:0]       clr_b
);

  localparam int NCH = 2;   // index 0 = channel A (higher priority)

  logic [NSRC-1:0]  src_arr [NCH];
  logic [EN_W-1:0]  en_arr  [NCH];
  logic [NCH-1:0]   elig;
  logic [LVL_W-1:0] lvl     [NCH];
  logic [NSRC-1:0]  oh      [NCH];

  assign src_arr[0] = src_a;
  assign src_arr[1] = src_b;
  assign en_arr[0]  = en_a;
  assign en_arr[1]  = en_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sio_chan_pick #(.EN_W(EN_W)) u_pick (
      .src    (src_arr[c]),
      .en     (en_arr[c]),
      .elig   (elig[c]),
      .lvl    (lvl[c]),
      .win_oh (oh[c])
    );
  end

  // named internal events
  logic                any_elig;
  logic                busy;
  logic                take;
  logic [NCH-1:0]      win_ch;
  logic [NCH*NSRC-1:0] win_src;
  logic [CODE_W-1:0]   win_code;
  logic [NCH-1:0]      insvc;
  logic [NCH*NSRC-1:0] clr_flat;

  assign any_elig = |elig;
  assign busy     = |insvc;

  always_comb begin
    win_ch   = '0;
    win_src  = '0;
    win_code = CODE_IDLE;
    if (!busy) begin
      if (elig[0]) begin
        win_ch[0]            = 1'b1;
        win_src[NSRC-1:0]    = oh[0];
        win_code             = mk_code(1'b1, lvl[0]);
      end else if (elig[1]) begin
        win_ch[1]            = 1'b1;
        win_src[2*NSRC-1:NSRC] = oh[1];
        win_code             = mk_code(1'b0, lvl[1]);
      end
    end
  end

  assign irq      = ei & any_elig & ~busy;
  assign eo       = ei & ~any_elig & ~busy;
  assign take     = ack & irq;
  assign ack_pass = ack & eo;

  sio_vec_fmt #(.VEC_W(VEC_W)) u_fmt (
    .base    (base_vec),
    .code    (win_code),
    .code_en (en_b[EN_VEC_BIT]),
    .mode    (vmode),
    .vec     (vec_now)
  );

  sio_svc_ctl #(.NCH(NCH), .VEC_W(VEC_W)) u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .reti    (reti),
    .win_ch  (win_ch),
    .win_src (win_src),
    .vec_in  (vec_now),
    .insvc   (insvc),
    .ack_vec (ack_vec),
    .ack_vld (ack_vld),
    .clr     (clr_flat)
  );

  assign clr_a = clr_flat[NSRC-1:0];
  assign clr_b = clr_flat[2*NSRC-1:NSRC];

endmodule

// File: rtl/sio_irq_vectoring_chk.sv
module sio_irq_vectoring_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ei,
  input logic       ack,
  input logic       reti,
  input logic       irq,
  input logic       eo,
  input logic       ack_vld,
  input logic       ack_pass,
  input logic [3:0] clr_a,
  input logic [3:0] clr_b,
  input logic [1:0] insvc
);

  // R13
  req_eo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(irq && eo));

  // R12
  ei_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !ei |-> (!irq && !eo && !ack_pass));

  // R1
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) ack_vld |-> $countones({clr_a, clr_b}) == 1);

  // R9
  vld_enters_svc_chk: assert property (@(posedge clk) disable iff (!rst_n) ack_vld |-> $countones(insvc) == 1);

  // R10
  svc_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n) (insvc != 2'b00) |-> (!irq && !eo));

  // R10
  svc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(insvc));

  // R11
  reti_release_chk: assert property (@(posedge clk) disable iff (!rst_n) (reti && !ack) |=> (insvc == 2'b00));

  // R9
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack_vld |=> !ack_vld || $past(ack));

endmodule

bind sio_irq_vectoring sio_irq_vectoring_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ei       (ei),
  .ack      (ack),
  .reti     (reti),
  .irq      (irq),
  .eo       (eo),
  .ack_vld  (ack_vld),
  .ack_pass (ack_pass),
  .clr_a    (clr_a),
  .clr_b    (clr_b),
  .insvc    (insvc)
);

// File: tb/tb_sio_irq_vectoring.sv
module tb_sio_irq_vectoring;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_a = '0, src_b = '0;
  logic [7:0] en_a = '0, en_b = '0;
  logic [7:0] base_vec = 8'hA5;
  logic [2:0] vmode = '0;
  logic       ei = 1'b1, ack = 1'b0, reti = 1'b0;
  logic       irq, eo, ack_vld, ack_pass;
  logic [7:0] vec_now, ack_vec;
  logic [3:0] clr_a, clr_b;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sio_irq_vectoring dut (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .en_a(en_a), .en_b(en_b),
    .base_vec(base_vec), .vmode(vmode), .ei(ei), .ack(ack), .reti(reti),
    .irq(irq), .eo(eo), .vec_now(vec_now), .ack_vec(ack_vec), .ack_vld(ack_vld),
    .ack_pass(ack_pass), .clr_a(clr_a), .clr_b(clr_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector restated by field splicing
  function automatic logic [7:0] exp_vec(input logic [7:0] b, input logic [2:0] code,
                                         input logic on, input logic [2:0] m);
    if (!on) return b;
    if (m == 3'd2 || m == 3'd3 || m == 3'd6) return {b[7:3], code};
    return {b[7:5], code, b[1:0]};
  endfunction

  task automatic settle();
    @(negedge clk); #1;
  endtask

  // acknowledge that must be taken; model source drops the cleared flag
  task automatic ack_taken(input string req, input logic [7:0] evec,
                           input logic [3:0] eca, input logic [3:0] ecb);
    @(negedge clk); ack = 1'b1; #1;
    check({req, " pass low on take"}, ack_pass, 0);
    @(negedge clk); ack = 1'b0; #1;
    check({req, " vld"}, ack_vld, 1);
    check({req, " vec"}, ack_vec, evec);
    check({req, " clr_a"}, clr_a, eca);
    check({req, " clr_b"}, clr_b, ecb);
    src_a = src_a & ~clr_a;
    src_b = src_b & ~clr_b;
    settle();
    check({req, " vld pulse ends"}, ack_vld, 0);
    check({req, " clr pulse ends"}, {clr_a, clr_b}, 0);
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0; #1;
  endtask

  task automatic t_reset();
    settle();
    check("R14 vld", ack_vld, 0);
    check("R14 clr", {clr_a, clr_b}, 0);
    check("R13 eo idle", eo, 1);
    check("R8 irq idle", irq, 0);
    check("R5 vec=base", vec_now, 8'hA5);
  endtask

  task automatic t_prio_a();
    en_a = 8'h1B; en_b = 8'h04; vmode = 3'd0;
    src_a = 4'hF; settle();
    check("R8 irq", irq, 1);
    check("R4 code err A", vec_now, exp_vec(8'hA5, 3'd7, 1, 0));
    ack_taken("R1 err", exp_vec(8'hA5, 3'd7, 1, 0), 4'b1000, 4'b0000);
    check("R10 irq locked", irq, 0);
    check("R10 eo locked", eo, 0);
    check("R4 idle in service", vec_now, exp_vec(8'hA5, 3'd7, 1, 0));
    do_reti();
    check("R11 irq back", irq, 1);
    ack_taken("R1 rx", exp_vec(8'hA5, 3'd6, 1, 0), 4'b0100, 4'b0000);
    do_reti();
    ack_taken("R1 stat", exp_vec(8'hA5, 3'd5, 1, 0), 4'b0010, 4'b0000);
    do_reti();
    ack_taken("R1 tx", exp_vec(8'hA5, 3'd4, 1, 0), 4'b0001, 4'b0000);
    do_reti();
    check("R13 eo after drain", eo, 1);
  endtask

  task automatic t_enables();
    src_a = 4'b0111; en_a = 8'h00; settle();
    check("R2 gated no irq", irq, 0);
    check("R2 gated eo", eo, 1);
    en_a = 8'h08; settle();
    check("R2 rx bit3", irq, 1);
    en_a = 8'h10; settle();
    check("R2 rx bit4", irq, 1);
    src_a = 4'b0010; en_a = 8'h01; settle();
    check("R2 stat en", irq, 1);
    src_a = 4'b0001; en_a = 8'h01; settle();
    check("R2 tx needs bit1", irq, 0);
    en_a = 8'h02; settle();
    check("R2 tx en", irq, 1);
    src_a = 4'b1000; en_a = 8'h00; settle();
    check("R2 err ungated", irq, 1);
    src_a = 4'b0000; settle();
  endtask

  task automatic t_chan_order();
    en_a = 8'h02; en_b = 8'h1F; vmode = 3'd2;
    src_a = 4'b0001; src_b = 4'b1000; settle();
    check("R3 A wins code", vec_now, exp_vec(8'hA5, 3'd4, 1, 2));
    ack_taken("R3 A tx", exp_vec(8'hA5, 3'd4, 1, 2), 4'b0001, 4'b0000);
    do_reti();
    ack_taken("R3 B err", exp_vec(8'hA5, 3'd3, 1, 2), 4'b0000, 4'b1000);
    do_reti();
  endtask

  task automatic t_modes();
    en_b = 8'h1F; src_b = 4'b0010;   // B status, code 1
    for (int m = 0; m < 8; m++) begin
      vmode = 3'(m); settle();
      check((m == 2 || m == 3 || m == 6) ? "R7 low field" : "R6 mid field",
            vec_now, exp_vec(8'hA5, 3'd1, 1, 3'(m)));
    end
    en_b = 8'h1B; vmode = 3'd0; settle();
    check("R5 code off", vec_now, 8'hA5);
    src_b = 4'b0000; en_b = 8'h1F; settle();
    check("R4 idle code", vec_now, exp_vec(8'hA5, 3'd7, 1, 0));
  endtask

  task automatic t_lockout();
    src_b = 4'b0100; settle();
    ack_taken("R9 B rx", exp_vec(8'hA5, 3'd2, 1, 0), 4'b0000, 4'b0100);
    src_a = 4'b1000; settle();
    check("R10 no irq", irq, 0);
    @(negedge clk); ack = 1'b1; #1;
    check("R10 ack not passed", ack_pass, 0);
    @(negedge clk); ack = 1'b0; #1;
    check("R10 no vld", ack_vld, 0);
    check("R10 no clr", {clr_a, clr_b}, 0);
    do_reti();
    check("R11 pending re-raises", irq, 1);
  endtask

  task automatic t_chain();
    ei = 1'b0; settle();
    check("R12 irq low", irq, 0);
    check("R12 eo low", eo, 0);
    @(negedge clk); ack = 1'b1; #1;
    check("R12 no pass", ack_pass, 0);
    @(negedge clk); ack = 1'b0; #1;
    check("R12 no vld", ack_vld, 0);
    check("R12 flag kept", irq, 0);
    ei = 1'b1; src_a = 4'b0000; settle();
    check("R13 eo follows ei", eo, 1);
    @(negedge clk); ack = 1'b1; #1;
    check("R13 ack passed", ack_pass, 1);
    @(negedge clk); ack = 1'b0; #1;
    check("R13 no own vector", ack_vld, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prio_a();
    t_enables();
    t_chan_order();
    t_modes();
    t_lockout();
    t_chain();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule